// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block decides the outcome of every branch instruction of a 32-bit RISC core whose instruction fields are numbered big-endian (bit 0 is the most significant bit). Each cycle it looks at the fetched instruction word, together with the address of that instruction, the 32-bit condition register, the count register and the link register. One cycle later it reports whether the word was a branch, whether the branch is taken, the target address, a static prediction hint, the new count value when the count is decremented, and the link-register value to write when the branch links.

Three branch shapes are recognised: an unconditional branch with a 24-bit word offset, a conditional branch with a 14-bit word offset, and an indirect conditional branch through the link or count register. A conditional branch may require one chosen condition-register bit to have a given value, may decrement the count register and test the new value for zero or non-zero, or may do both. Relative targets add the displacement to the address of the branch itself. Fetch redirection, pipeline flush and dynamic prediction belong to the surrounding core.

Top module: `brx_resolve_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every output is zero.
- R2: Major opcode 18 (instruction bits 31:26) is an unconditional branch: always taken, hint 1, byte displacement = sign-extended instruction bits 25:2 followed by two zero bits; instruction bit 1 (absolute flag) set gives target = displacement, clear gives target = instruction address + displacement.
- R3: Major opcode 16 is a conditional branch whose byte displacement is sign-extended instruction bits 15:2 followed by two zero bits, with the same absolute/relative rule as R2.
- R4: The condition field sits in instruction bits 25:21 (its first bit is instruction bit 25) and the bit selector in bits 20:16. If the first condition bit is 1 the condition register is not consulted; otherwise the branch needs condition-register bit (31 − selector) to equal the second condition bit (instruction bit 24).
- R5: If the third condition bit (instruction bit 23) is 0 the count register is decremented, the new value is written out whether or not the branch is taken, and the fourth bit (instruction bit 22) picks the test: 0 needs new count ≠ 0, 1 needs new count = 0. If the third bit is 1 the count is not written and not tested.
- R6: A conditional branch is taken only when both the condition-register test of R4 and the count test of R5 pass.
- R7: Instruction bit 0 set on any recognised legal branch writes the link register with instruction address + 4, taken or not.
- R8: Opcode 19 with extended code 16 (instruction bits 10:1) branches to the link register, extended code 528 to the count register, each with its two low bits cleared, under the conditions of R4 to R6.
- R9: An indirect branch to the count register whose third condition bit is 0 raises the illegal flag, is not taken, and writes neither the count nor the link register.
- R10: The hint is the default prediction XOR the last condition bit (instruction bit 21); the default is 1 for a conditional branch with negative displacement and 0 for forward and indirect branches.
- R11: Any other instruction word gives branch-valid 0 and all other outputs 0.
- R12: All outputs are registered: they reflect the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inst_i | input | 32 | Fetched instruction word |
| pc_i | input | XLEN | Address of that instruction |
| cr_i | input | 32 | Condition register, bit 0 = MSB |
| ctr_i | input | XLEN | Count register |
| lr_i | input | XLEN | Link register |
| br_valid_o | output | 1 | Instruction was a recognised branch |
| taken_o | output | 1 | Branch is taken |
| target_o | output | XLEN | Branch target address |
| hint_o | output | 1 | Static prediction hint |
| illegal_o | output | 1 | Indirect-through-count with decrement |
| ctr_we_o | output | 1 | Count register write enable |
| ctr_o | output | XLEN | New count value |
| lr_we_o | output | 1 | Link register write enable |
| lr_o | output | XLEN | Return address to write |

## Verification
The bench builds the unit with its default parameters: a 32-bit address width and the standard opcode and extended-code values for the three branch shapes. At that width the 26-bit unconditional displacement sign-extends into the upper address bits, so absolute branches to negative offsets wrap to high addresses, and count values of 0 and 1 exercise the wrap to all ones and the decrement to zero. Directed vectors cover every condition-field combination of interest, then several thousand random words, weighted towards branch opcodes and small count values, are compared against a behavioural model field by field.

// File: rtl/brx_pkg.sv
package brx_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned CR_W   = 32;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_REL  = 2'd1,
    K_COND = 2'd2,
    K_IND  = 2'd3
  } br_kind_e;
endpackage

// File: rtl/brx_field_decode.sv
module brx_field_decode
  import brx_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int OPC_REL   = 18,
  parameter int OPC_COND  = 16,
  parameter int OPC_XL    = 19,
  parameter int XO_TO_LR  = 16,
  parameter int XO_TO_CTR = 528
) (
  input  logic [INSN_W-1:0] inst,
  output br_kind_e          kind,
  output logic              ind_ctr,
  output logic              aa,
  output logic              lk,
  output logic [0:4]        bo,
  output logic [4:0]        bi,
  output logic [XLEN-1:0]   disp
);
  localparam int LI_W = 24;
  localparam int BD_W = 14;

  logic [5:0] opc;
  logic [9:0] xo;

  function automatic logic [XLEN-1:0] sx_long(input logic [LI_W-1:0] li);
    return {{(XLEN-LI_W-2){li[LI_W-1]}}, li, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] sx_short(input logic [BD_W-1:0] bd);
    return {{(XLEN-BD_W-2){bd[BD_W-1]}}, bd, 2'b00};
  endfunction

  assign opc = inst[31:26];
  assign xo  = inst[10:1];
  assign bo  = inst[25:21];
  assign bi  = inst[20:16];
  assign aa  = inst[1];
  assign lk  = inst[0];

  always_comb begin
    kind    = K_NONE;
    ind_ctr = 1'b0;
    disp    = '0;
    if (opc == 6'(OPC_REL)) begin
      kind = K_REL;
      disp = sx_long(inst[25:2]);
    end else if (opc == 6'(OPC_COND)) begin
      kind = K_COND;
      disp = sx_short(inst[15:2]);
    end else if (opc == 6'(OPC_XL)) begin
      if (xo == 10'(XO_TO_LR)) begin
        kind = K_IND;
      end else if (xo == 10'(XO_TO_CTR)) begin
        kind    = K_IND;
        ind_ctr = 1'b1;
      end
    end
  end
endmodule

// File: rtl/brx_cond_eval.sv
module brx_cond_eval
  import brx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  br_kind_e        kind,
  input  logic            ind_ctr,
  input  logic [0:3]      bo_hi,
  input  logic [4:0]      bi,
  input  logic [CR_W-1:0] cr,
  input  logic [XLEN-1:0] ctr,
  output logic            cr_ok,
  output logic            ctr_ok,
  output logic            ctr_dec,
  output logic            illegal,
  output logic            taken,
  output logic [XLEN-1:0] ctr_new
);
  logic is_cond;
  logic cr_bit;

  function automatic logic pick_cr(input logic [CR_W-1:0] c, input logic [4:0] idx);
    return c[5'(CR_W-1) - idx];
  endfunction

  function automatic logic cr_test(input logic ign, input logic want, input logic bitv);
    return ign | (bitv == want);
  endfunction

  function automatic logic ctr_test(input logic nodec, input logic want_zero,
                                    input logic [XLEN-1:0] v);
    return nodec | ((v == '0) == want_zero);
  endfunction

  assign is_cond = (kind == K_COND) || (kind == K_IND);
  assign cr_bit  = pick_cr(cr, bi);
  assign illegal = (kind == K_IND) && ind_ctr && !bo_hi[2];
  assign ctr_new = ctr - XLEN'(1);
  assign cr_ok   = cr_test(bo_hi[0], bo_hi[1], cr_bit);
  assign ctr_ok  = ctr_test(bo_hi[2], bo_hi[3], ctr_new);
  assign ctr_dec = is_cond && !bo_hi[2] && !illegal;
  assign taken   = (kind == K_REL) || (is_cond && !illegal && cr_ok && ctr_ok);
endmodule

// File: rtl/brx_target_gen.sv
module brx_target_gen
  import brx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  br_kind_e        kind,
  input  logic            ind_ctr,
  input  logic            aa,
  input  logic            y_bit,
  input  logic [XLEN-1:0] disp,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] lr,
  input  logic [XLEN-1:0] ctr,
  output logic [XLEN-1:0] target,
  output logic [XLEN-1:0] ret_addr,
  output logic            hint
);
  function automatic logic [XLEN-1:0] rel_target(input logic abs_f, input logic [XLEN-1:0] base,
                                                 input logic [XLEN-1:0] d);
    return abs_f ? d : base + d;
  endfunction

  function automatic logic [XLEN-1:0] word_align(input logic [XLEN-1:0] a);
    return a & ~XLEN'(3);
  endfunction

  assign ret_addr = pc + XLEN'(4);

  always_comb begin
    target = '0;
    hint   = 1'b0;
    unique case (kind)
      K_REL: begin
        target = rel_target(aa, pc, disp);
        hint   = 1'b1;
      end
      K_COND: begin
        target = rel_target(aa, pc, disp);
        hint   = disp[XLEN-1] ^ y_bit;
      end
      K_IND: begin
        target = word_align(ind_ctr ? ctr : lr);
        hint   = y_bit;
      end
      default: begin
        target = '0;
        hint   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/brx_resolve_unit.sv
module brx_resolve_unit
  import brx_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int OPC_REL   = 18,
  parameter int OPC_COND  = 16,
  parameter int OPC_XL    = 19,
  parameter int XO_TO_LR  = 16,
  parameter int XO_TO_CTR = 528
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INSN_W-1:0] inst_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [CR_W-1:0]   cr_i,
  input  logic [XLEN-1:0]   ctr_i,
  input  logic [XLEN-1:0]   lr_i,
  output logic              br_valid_o,
  output logic              taken_o,
  output logic [XLEN-1:0]   target_o,
  output logic              hint_o,
  output logic              illegal_o,
  output logic              ctr_we_o,
  output logic [XLEN-1:0]   ctr_o,
  output logic              lr_we_o,
  output logic [XLEN-1:0]   lr_o
);
  br_kind_e        d_kind;
  logic            d_ind_ctr, d_aa, d_lk;
  logic [0:4]      d_bo;
  logic [4:0]      d_bi;
  logic [XLEN-1:0] d_disp;

  logic            e_cr_ok, e_ctr_ok, e_ctr_dec, e_illegal, e_taken;
  logic [XLEN-1:0] e_ctr_new;

  logic [XLEN-1:0] t_target, t_ret;
  logic            t_hint;

  logic            ev_is_branch;
  logic            ev_lr_write;

  brx_field_decode #(
    .XLEN(XLEN), .OPC_REL(OPC_REL), .OPC_COND(OPC_COND), .OPC_XL(OPC_XL),
    .XO_TO_LR(XO_TO_LR), .XO_TO_CTR(XO_TO_CTR)
  ) u_dec (
    .inst(inst_i), .kind(d_kind), .ind_ctr(d_ind_ctr), .aa(d_aa), .lk(d_lk),
    .bo(d_bo), .bi(d_bi), .disp(d_disp)
  );

  brx_cond_eval #(.XLEN(XLEN)) u_cond (
    .kind(d_kind), .ind_ctr(d_ind_ctr), .bo_hi(d_bo[0:3]), .bi(d_bi), .cr(cr_i),
    .ctr(ctr_i), .cr_ok(e_cr_ok), .ctr_ok(e_ctr_ok), .ctr_dec(e_ctr_dec),
    .illegal(e_illegal), .taken(e_taken), .ctr_new(e_ctr_new)
  );

  brx_target_gen #(.XLEN(XLEN)) u_tgt (
    .kind(d_kind), .ind_ctr(d_ind_ctr), .aa(d_aa), .y_bit(d_bo[4]), .disp(d_disp),
    .pc(pc_i), .lr(lr_i), .ctr(ctr_i), .target(t_target), .ret_addr(t_ret),
    .hint(t_hint)
  );

  assign ev_is_branch = (d_kind != K_NONE);
  assign ev_lr_write  = ev_is_branch && d_lk && !e_illegal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      br_valid_o <= 1'b0;
      taken_o    <= 1'b0;
      target_o   <= '0;
      hint_o     <= 1'b0;
      illegal_o  <= 1'b0;
      ctr_we_o   <= 1'b0;
      ctr_o      <= '0;
      lr_we_o    <= 1'b0;
      lr_o       <= '0;
    end else begin
      br_valid_o <= ev_is_branch;
      taken_o    <= e_taken;
      target_o   <= t_target;
      hint_o     <= t_hint;
      illegal_o  <= e_illegal;
      ctr_we_o   <= e_ctr_dec;
      ctr_o      <= e_ctr_dec ? e_ctr_new : '0;
      lr_we_o    <= ev_lr_write;
      lr_o       <= ev_lr_write ? t_ret : '0;
    end
  end
endmodule

// File: rtl/brx_resolve_unit_chk.sv
module brx_resolve_unit_chk #(
  parameter int XLEN    = 32,
  parameter int OPC_REL = 18
) (
  input logic            clk,
  input logic            rst_n,
  input logic [31:0]     inst_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] ctr_i,
  input logic            br_valid_o,
  input logic            taken_o,
  input logic [XLEN-1:0] target_o,
  input logic            illegal_o,
  input logic            ctr_we_o,
  input logic [XLEN-1:0] ctr_o,
  input logic            lr_we_o,
  input logic [XLEN-1:0] lr_o
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_taken_needs_branch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> br_valid_o);

  p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!taken_o && !ctr_we_o && !lr_we_o));

  p_ctr_minus_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && ctr_we_o) |-> (ctr_o == $past(ctr_i) - XLEN'(1)));

  p_link_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && lr_we_o) |-> (lr_o == $past(pc_i) + XLEN'(4)));

  p_uncond_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(inst_i[31:26]) == 6'(OPC_REL)) |-> (taken_o && br_valid_o));

  p_target_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid_o |-> (target_o[1:0] == 2'b00));
endmodule

bind brx_resolve_unit brx_resolve_unit_chk #(.XLEN(XLEN), .OPC_REL(OPC_REL)) u_chk (.*);

// File: tb/brx_resolve_unit_bench.sv
module brx_resolve_unit_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        bv, tk, hn, il, cw, lw;
    logic [31:0] tg, cv, lv;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] inst_i = '0, pc_i = '0, cr_i = '0, ctr_i = '0, lr_i = '0;
  logic        br_valid_o, taken_o, hint_o, illegal_o, ctr_we_o, lr_we_o;
  logic [31:0] target_o, ctr_o, lr_o;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 0;
  bit   have_prev = 0;
  exp_t prev_exp;
  string prev_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  brx_resolve_unit u_brx_resolve_unit (
    .clk(clk), .rst_n(rst_n), .inst_i(inst_i), .pc_i(pc_i), .cr_i(cr_i),
    .ctr_i(ctr_i), .lr_i(lr_i), .br_valid_o(br_valid_o), .taken_o(taken_o),
    .target_o(target_o), .hint_o(hint_o), .illegal_o(illegal_o),
    .ctr_we_o(ctr_we_o), .ctr_o(ctr_o), .lr_we_o(lr_we_o), .lr_o(lr_o)
  );

  // Behavioural model: fields taken by big-endian bit positions.
  function automatic int unsigned fld(bit [31:0] w, int be_hi, int be_lo);
    return (w >> (31 - be_lo)) & ((1 << (be_lo - be_hi + 1)) - 1);
  endfunction

  function automatic exp_t model(bit [31:0] ins, bit [31:0] pc, bit [31:0] cr,
                                 bit [31:0] ctr, bit [31:0] lr);
    exp_t e = '0;
    int unsigned opc = fld(ins, 0, 5);
    int unsigned bo  = fld(ins, 6, 10);
    int unsigned bi  = fld(ins, 11, 15);
    int unsigned xo  = fld(ins, 21, 30);
    bit aa = fld(ins, 30, 30) != 0;
    bit lk = fld(ins, 31, 31) != 0;
    bit ign_cr = (bo & 16) != 0, want = (bo & 8) != 0, nodec = (bo & 4) != 0;
    bit wantz = (bo & 2) != 0, y = (bo & 1) != 0;
    int off;
    bit [31:0] nc = ctr - 1;
    bit crok, ctok;
    if (opc == 18) begin
      off = int'(ins & 32'h03FF_FFFC);
      if (ins[25]) off = off - 32'h0400_0000;
      e.bv = 1; e.tk = 1; e.hn = 1;
      e.tg = aa ? 32'(off) : pc + 32'(off);
    end else if (opc == 16 || (opc == 19 && (xo == 16 || xo == 528))) begin
      e.bv = 1;
      if (opc == 16) begin
        off = int'(ins & 32'h0000_FFFC);
        if (ins[15]) off = off - 32'h0001_0000;
        e.tg = aa ? 32'(off) : pc + 32'(off);
        e.hn = (off < 0) ^ y;
      end else begin
        e.tg = ((xo == 528) ? ctr : lr) & 32'hFFFF_FFFC;
        e.hn = y;
      end
      e.il = (opc == 19 && xo == 528 && !nodec);
      crok = ign_cr || (((cr >> (31 - bi)) & 1) == 32'(want));
      ctok = nodec || ((nc == 0) == wantz);
      e.tk = !e.il && crok && ctok;
      e.cw = !nodec && !e.il;
      e.cv = e.cw ? nc : 0;
    end
    if (e.bv && lk && !e.il) begin
      e.lw = 1; e.lv = pc + 4;
    end
    return e;
  endfunction

  task automatic chk1(string tag, string nm, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
    end
  endtask

  task automatic compare(string tag, exp_t e);
    chk1(tag, "br_valid", 32'(br_valid_o), 32'(e.bv));
    chk1(tag, "taken",    32'(taken_o),    32'(e.tk));
    chk1(tag, "target",   target_o,        e.tg);
    chk1(tag, "hint",     32'(hint_o),     32'(e.hn));
    chk1(tag, "illegal",  32'(illegal_o),  32'(e.il));
    chk1(tag, "ctr_we",   32'(ctr_we_o),   32'(e.cw));
    chk1(tag, "ctr",      ctr_o,           e.cv);
    chk1(tag, "lr_we",    32'(lr_we_o),    32'(e.lw));
    chk1(tag, "lr",       lr_o,            e.lv);
  endtask

  // R12: the outputs seen one cycle after a vector belong to that vector.
  task automatic apply(string tag, bit [31:0] ins, bit [31:0] pc, bit [31:0] cr,
                       bit [31:0] ctr, bit [31:0] lr);
    @(negedge clk);
    if (have_prev) compare(prev_tag, prev_exp);
    inst_i = ins; pc_i = pc; cr_i = cr; ctr_i = ctr; lr_i = lr;
    prev_exp = model(ins, pc, cr, ctr, lr);
    prev_tag = tag;
    have_prev = 1;
    n_vec++;
  endtask

  function automatic bit [31:0] mk_b(bit [23:0] li, bit aa, bit lk);
    return (32'd18 << 26) | (32'(li) << 2) | (32'(aa) << 1) | 32'(lk);
  endfunction
  function automatic bit [31:0] mk_bc(bit [4:0] bo, bit [4:0] bi, bit [13:0] bd, bit aa, bit lk);
    return (32'd16 << 26) | (32'(bo) << 21) | (32'(bi) << 16) | (32'(bd) << 2)
           | (32'(aa) << 1) | 32'(lk);
  endfunction
  function automatic bit [31:0] mk_xl(bit [4:0] bo, bit [4:0] bi, bit [9:0] xo, bit lk);
    return (32'd19 << 26) | (32'(bo) << 21) | (32'(bi) << 16) | (32'(xo) << 1) | 32'(lk);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: outputs cleared in reset.
    repeat (3) @(negedge clk);
    n_vec++;
    compare("R1", '0);
    @(negedge clk);
    rst_n = 1'b1;
    n_vec++;
    compare("R1", '0);

    // R2: unconditional, relative and absolute, both signs.
    apply("R2", mk_b(24'h000010, 0, 0), 32'h0000_1000, 0, 0, 0);
    apply("R2", mk_b(24'hFFFFFC, 0, 0), 32'h0000_1000, 0, 0, 0);
    apply("R2", mk_b(24'h800000, 1, 0), 32'h1234_5678, 0, 0, 0);
    apply("R2", mk_b(24'h7FFFFF, 0, 0), 32'hFFFF_FFF0, 0, 0, 0);
    // R3: conditional displacement, branch-always encoding.
    apply("R3", mk_bc(5'b10100, 0, 14'h0002, 0, 0), 32'h0000_2000, 0, 0, 0);
    apply("R3", mk_bc(5'b10100, 0, 14'h3FFF, 1, 0), 32'h0000_2000, 0, 0, 0);
    apply("R3", mk_bc(5'b10100, 0, 14'h2000, 0, 0), 32'h0000_0100, 0, 0, 0);
    // R4: CR bit selection with bit 0 as MSB.
    apply("R4", mk_bc(5'b01100, 0, 14'h0004, 0, 0), 32'h100, 32'h8000_0000, 0, 0);
    apply("R4", mk_bc(5'b01100, 0, 14'h0004, 0, 0), 32'h100, 32'h0000_0001, 0, 0);
    apply("R4", mk_bc(5'b01100, 31, 14'h0004, 0, 0), 32'h100, 32'h0000_0001, 0, 0);
    apply("R4", mk_bc(5'b00100, 31, 14'h0004, 0, 0), 32'h100, 32'h0000_0001, 0, 0);
    apply("R4", mk_bc(5'b00100, 5, 14'h0004, 0, 0), 32'h100, 32'hFBFF_FFFF, 0, 0);
    // R5: CTR decrement and zero / non-zero test.
    apply("R5", mk_bc(5'b10000, 0, 14'h0004, 0, 0), 32'h100, 0, 32'd1, 0);
    apply("R5", mk_bc(5'b10000, 0, 14'h0004, 0, 0), 32'h100, 0, 32'd5, 0);
    apply("R5", mk_bc(5'b10010, 0, 14'h0004, 0, 0), 32'h100, 0, 32'd1, 0);
    apply("R5", mk_bc(5'b10000, 0, 14'h0004, 0, 0), 32'h100, 0, 32'd0, 0);
    // R6: both tests combined.
    apply("R6", mk_bc(5'b01000, 2, 14'h0004, 0, 0), 32'h100, 32'h2000_0000, 32'd3, 0);
    apply("R6", mk_bc(5'b01000, 2, 14'h0004, 0, 0), 32'h100, 32'h2000_0000, 32'd1, 0);
    apply("R6", mk_bc(5'b01000, 2, 14'h0004, 0, 0), 32'h100, 32'h0, 32'd3, 0);
    apply("R6", mk_bc(5'b00010, 7, 14'h0004, 0, 0), 32'h100, 32'h0, 32'd1, 0);
    // R7: link write, taken or not.
    apply("R7", mk_b(24'h000001, 0, 1), 32'h0000_4000, 0, 0, 0);
    apply("R7", mk_bc(5'b01100, 0, 14'h0004, 0, 1), 32'h0000_4000, 0, 0, 0);
    // R8: indirect through LR and CTR.
    apply("R8", mk_xl(5'b10100, 0, 10'd16, 0), 32'h0, 0, 32'h0000_4007, 32'h0000_2003);
    apply("R8", mk_xl(5'b10100, 0, 10'd528, 1), 32'h50, 0, 32'h0000_4007, 32'h0000_2003);
    apply("R8", mk_xl(5'b10000, 0, 10'd16, 0), 32'h0, 0, 32'd1, 32'h0000_2003);
    // R9: illegal indirect-through-CTR with decrement.
    apply("R9", mk_xl(5'b10000, 0, 10'd528, 1), 32'h60, 0, 32'd9, 0);
    apply("R9", mk_xl(5'b00000, 3, 10'd528, 0), 32'h60, 0, 32'd2, 0);
    // R10: static prediction hint.
    apply("R10", mk_bc(5'b10100, 0, 14'h3FF0, 0, 0), 32'h800, 0, 0, 0);
    apply("R10", mk_bc(5'b10101, 0, 14'h3FF0, 0, 0), 32'h800, 0, 0, 0);
    apply("R10", mk_bc(5'b10101, 0, 14'h0010, 0, 0), 32'h800, 0, 0, 0);
    apply("R10", mk_xl(5'b10101, 0, 10'd16, 0), 32'h800, 0, 0, 32'h44);
    // R11: non-branch words.
    apply("R11", 32'h7C00_0214, 32'h900, 32'hFFFF_FFFF, 32'd1, 32'h44);
    apply("R11", mk_xl(5'b10100, 0, 10'd17, 1), 32'h900, 0, 32'd1, 32'h44);
    apply("R11", 32'h0000_0000, 32'h900, 0, 0, 0);

    // Random mix, weighted towards branches and small counts.
    for (int k = 0; k < 3000; k++) begin
      bit [31:0] w = $urandom;
      bit [31:0] c;
      int sel = $urandom_range(0, 5);
      case (sel)
        0: w = mk_b(w[23:0], w[30], w[31]);
        1, 2: w = mk_bc(w[4:0], w[9:5], w[23:10], w[30], w[31]);
        3: w = mk_xl(w[4:0], w[9:5], w[31] ? 10'd528 : 10'd16, w[30]);
        default: ;
      endcase
      case ($urandom_range(0, 3))
        0: c = 0;
        1: c = 1;
        2: c = 2;
        default: c = $urandom;
      endcase
      apply("R6", w, $urandom & 32'hFFFF_FFFC, $urandom, c, $urandom);
    end

    @(negedge clk);
    compare(prev_tag, prev_exp);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule